// File: doc/BRIEF.md
# Tone Burst Gating Controller

This block gates a 22 kHz square tone onto a transmit output. A divider on the system clock sets the tone timing. Each half of a tone cycle is `HALF_DIV` clocks long, written H below. Three sources can ask for the tone, and their requests are ORed:

- a continuous-tone control bit;
- a level key input;
- an external key input that carries a 22 kHz logic signal. This signal only marks when a burst begins and ends. The waveform always comes from the internal divider.

No tone appears unless the transmit path is allowed. The path is allowed when the power enable is high and either the pin or the register form of the transmit enable is high. The block reports when a burst is running through a transmit-active flag.

Each key source has its own start and stop latency. The level key starts a burst after half a tone cycle and stops it after one cycle. The external carrier starts a burst after one and a half cycles and stops it after two. Every burst begins with a full high half. A burst ends only at the end of a complete cycle, so no runt pulse is ever produced.

Top module: `tone_burst_gate`

## Requirements
- R1: While `pwr_en` is low, or both `txen_pin` and `txen_bit` are low, `tone_out` is 0 at once and `tx_active` is 0 from the next clock on.
- R2: With the path allowed and `cont_tone` high, the burst starts on the first clock edge that samples the request. `tone_out` is then high for H clocks and low for H clocks, repeating with period 2H.
- R3: Suppose `key_lvl` is sampled high on H+1 consecutive edges, the first being edge t. The level request then rises after edge t+H, and `tx_active` rises after edge t+H+1. A shorter high pulse has no effect.
- R4: The level request drops after `key_lvl` has been sampled low on 2H+1 consecutive edges.
- R5: A rising edge of `key_ext` sampled at edge t starts a carrier train. The train stays alive while each further rising edge follows the previous one within 2H+H/4 clocks. If the train is still alive at edge t+3H, the external request rises, and `tx_active` rises after edge t+3H+1. A single isolated rising edge has no effect.
- R6: The external request drops after the edge that comes 4H clocks after the last sampled rising edge of `key_ext`.
- R7: A burst that starts after edge s begins with the high half. It ends only at an edge s+2Hk (k at least 1) at which no request is present. `tx_active` falls after that edge.
- R8: Requests from the three sources are ORed. While any one of them holds, the tone keeps running without a break in its pattern.
- R9: After reset, and with no request, `tone_out` and `tx_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Power section enable; low forces the transmit path off |
| txen_pin | input | 1 | Transmit-path enable, pin form |
| txen_bit | input | 1 | Transmit-path enable, register form |
| cont_tone | input | 1 | Continuous tone request |
| key_lvl | input | 1 | Level key input |
| key_ext | input | 1 | External 22 kHz carrier key input |
| tone_out | output | 1 | Gated tone waveform |
| tx_active | output | 1 | High while a burst is running |

## Verification
The bench builds the block with `HALF_DIV` = 4, so one tone cycle is 8 clocks. At that size the bench sweeps every level pulse length from 1 to 5H clocks and external trains of 1 to 4 carrier cycles. This covers the minimum-length pulse, the single isolated edge, and each possible distance between a request withdrawal and the next cycle boundary. The expected start cycle, end boundary and waveform phase are all computed in closed form.

// File: rtl/tone_burst_gate.sv
module tone_burst_gate #(
  parameter int HALF_DIV = 2841
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic txen_pin,
  input  logic txen_bit,
  input  logic cont_tone,
  input  logic key_lvl,
  input  logic key_ext,
  output logic tone_out,
  output logic tx_active
);
  localparam int CW  = $clog2(4*HALF_DIV+1);
  localparam int WIN = 2*HALF_DIV + HALF_DIV/4;
  localparam logic [CW-1:0] HM1  = CW'(HALF_DIV-1);
  localparam logic [CW-1:0] H1   = CW'(HALF_DIV);
  localparam logic [CW-1:0] H2   = CW'(2*HALF_DIV);
  localparam logic [CW-1:0] RMAX = CW'(3*HALF_DIV-1);
  localparam logic [CW-1:0] GMAX = CW'(4*HALF_DIV-1);
  localparam logic [CW-1:0] WINC = CW'(WIN);

  logic tx_ok, req;
  logic lvl_act, ext_act, ext_q, trn, burst, ph;
  logic [CW-1:0] lvl_cnt, gap, run, div;

  assign tx_ok = pwr_en & (txen_pin | txen_bit);
  assign req   = tx_ok & (cont_tone | lvl_act | ext_act);

  // level key: half-cycle start, full-cycle stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_act <= 1'b0;
      lvl_cnt <= '0;
    end else if (key_lvl == lvl_act) begin
      lvl_cnt <= '0;
    end else if (!lvl_act && lvl_cnt == H1) begin
      lvl_act <= 1'b1;
      lvl_cnt <= '0;
    end else if (lvl_act && lvl_cnt == H2) begin
      lvl_act <= 1'b0;
      lvl_cnt <= '0;
    end else begin
      lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  // external carrier: train of rising edges within the window
  wire ext_rise = key_ext & ~ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      gap     <= '0;
      trn     <= 1'b0;
      run     <= '0;
      ext_act <= 1'b0;
    end else begin
      ext_q <= key_ext;
      if (ext_rise)          gap <= '0;
      else if (gap != GMAX)  gap <= gap + 1'b1;
      if (ext_rise)          trn <= 1'b1;
      else if (gap >= WINC)  trn <= 1'b0;
      if (ext_rise && !trn)         run <= '0;
      else if (trn && run != RMAX)  run <= run + 1'b1;
      if (trn && run == RMAX)  ext_act <= 1'b1;
      else if (gap == GMAX)    ext_act <= 1'b0;
    end
  end

  // restartable tone generator, cycle-aligned gating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst <= 1'b0;
      ph    <= 1'b0;
      div   <= '0;
    end else if (!tx_ok) begin
      burst <= 1'b0;
      ph    <= 1'b0;
      div   <= '0;
    end else if (!burst) begin
      if (req) begin
        burst <= 1'b1;
        ph    <= 1'b1;
        div   <= '0;
      end
    end else if (div == HM1) begin
      div <= '0;
      if (!ph && !req) burst <= 1'b0;
      else             ph    <= ~ph;
    end else begin
      div <= div + 1'b1;
    end
  end

  assign tone_out  = burst & ph & tx_ok;
  assign tx_active = burst;

  a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ok |=> !tx_active);
  a_r7_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_active) && tx_ok) |-> tone_out);
  a_r7_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_active) && $past(tx_ok)) |-> !$past(tone_out));
  a_r3_lvl_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_act) |-> $past(key_lvl));
  a_r4_lvl_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_act) |-> !$past(key_lvl));
  a_r5_ext_train: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_act) |-> $past(trn));
endmodule

// File: tb/tone_burst_gate_tb.sv
module tone_burst_gate_tb;
  localparam int H   = 4;
  localparam int BIG = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_en = 1'b0, txen_pin = 1'b0, txen_bit = 1'b0;
  logic cont_tone = 1'b0, key_lvl = 1'b0, key_ext = 1'b0;
  logic tone_out, tx_active;

  int cyc = 0, nvec = 0, nbad = 0;
  int es = 0, ee = 0;
  bit mute = 1'b0;

  tone_burst_gate #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .txen_pin(txen_pin),
    .txen_bit(txen_bit), .cont_tone(cont_tone), .key_lvl(key_lvl),
    .key_ext(key_ext), .tone_out(tone_out), .tx_active(tx_active));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int endat(int s, int r);
    return s + 2*H*((r - s + 2*H - 1) / (2*H));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string rq);
    bit ea, et;
    #1;
    ea = (cyc >= es) && (cyc < ee);
    et = ea && !mute && (((cyc - es) % (2*H)) < H);
    nvec++;
    if (tx_active !== ea || tone_out !== et) begin
      nbad++;
      $display("FAIL %s cyc=%0d act=%b tone=%b expected act=%b tone=%b",
               rq, cyc, tx_active, tone_out, ea, et);
    end
  endtask

  task automatic watch_until(int last, string rq);
    while (cyc < last) begin
      tick();
      chk(rq);
    end
  endtask

  initial begin
    #(200000 * 8);
    nbad++;
    $display("FAIL watchdog expired at cyc=%0d expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int c0, d;
    repeat (3) begin tick(); chk("R9 reset"); end
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin tick(); chk("R9 idle"); end
    pwr_en = 1'b1;
    txen_bit = 1'b1;

    // R3 R4 R7: level pulse length sweep
    for (int L = 1; L <= 5*H; L++) begin
      tick();
      key_lvl = 1'b1;
      c0 = cyc;
      if (L >= H + 1) begin
        es = c0 + H + 2;
        ee = endat(es, c0 + L + 2*H + 2);
      end else begin
        es = 0; ee = 0;
      end
      chk("R3 level start");
      for (int j = 1; j < L; j++) begin tick(); chk("R3 level start"); end
      tick();
      key_lvl = 1'b0;
      chk("R4 level stop");
      watch_until(c0 + L + 6*H + 4, "R4 R7 level stop boundary");
    end

    // R5 R6 R7: external carrier train length sweep
    for (int M = 1; M <= 4; M++) begin
      tick();
      c0 = cyc;
      if (M >= 2) begin
        es = c0 + 3*H + 2;
        ee = endat(es, c0 + 2*H*(M-1) + 4*H + 2);
      end else begin
        es = 0; ee = 0;
      end
      for (int j = 0; j <= 2*H*(M+3) + 4; j++) begin
        if (j > 0) tick();
        key_ext = (j < 2*H*M) && ((j % (2*H)) < H);
        chk(M >= 2 ? "R5 R6 ext carrier" : "R5 isolated edge ignored");
      end
    end

    // R2: continuous tone
    tick();
    cont_tone = 1'b1;
    es = cyc + 1; ee = BIG;
    chk("R2 continuous");
    for (int i = 0; i < 6*H; i++) begin tick(); chk("R2 continuous"); end

    // R1: enable removal silences at once
    tick();
    txen_bit = 1'b0;
    mute = 1'b1;
    ee = cyc + 1;
    chk("R1 enable bit dropped");
    for (int i = 0; i < 3*H; i++) begin tick(); chk("R1 enable bit dropped"); end
    tick();
    txen_pin = 1'b1;
    mute = 1'b0;
    es = cyc + 1; ee = BIG;
    chk("R1 pin enable");
    for (int i = 0; i < 4*H; i++) begin tick(); chk("R1 pin enable"); end
    tick();
    pwr_en = 1'b0;
    mute = 1'b1;
    ee = cyc + 1;
    chk("R1 power enable low");
    for (int i = 0; i < 2*H; i++) begin tick(); chk("R1 power enable low"); end
    tick();
    pwr_en = 1'b1;
    mute = 1'b0;
    es = cyc + 1; ee = BIG;
    chk("R2 restart");
    for (int i = 0; i < 3*H + 1; i++) begin tick(); chk("R2 restart"); end
    tick();
    cont_tone = 1'b0;
    d = cyc;
    ee = endat(es, d + 1);
    chk("R7 continuous stop");
    watch_until(ee + 2*H, "R7 continuous stop");

    // R8: level and continuous requests overlap
    tick();
    key_lvl = 1'b1;
    c0 = cyc;
    es = c0 + H + 2; ee = BIG;
    chk("R8 or");
    watch_until(c0 + 3*H, "R8 or");
    tick();
    cont_tone = 1'b1;
    chk("R8 or");
    watch_until(c0 + 6*H, "R8 or");
    tick();
    key_lvl = 1'b0;
    chk("R8 or");
    watch_until(c0 + 12*H + 1, "R8 or");
    tick();
    cont_tone = 1'b0;
    ee = endat(es, cyc + 1);
    chk("R8 R7 or stop");
    watch_until(ee + 2*H, "R8 R7 or stop");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule